// File: doc/BRIEF.md
# Serially Programmed Switch-Enable Register

This block is a two-wire (I2C-style) bus target that owns a single 8-bit control word. Each bit of that word enables one analog switch outside the block. A bus master addresses the target and writes one or more bytes. Each complete byte becomes the new switch pattern, and any mix of switches (all, none or some) may be on together. A read returns the stored word. The block has no pointer or sub-address: the byte that follows the address is the word itself.

Both bus lines are sampled by the system clock. They are first synchronized and then filtered, so that short spikes are rejected. The data line output is an open-drain pull-down enable.

When a new word lands, switches that must open are opened at once. Switches that must close are closed only after a programmable settling gap. This prevents two sources from being briefly shorted together during a change.

Top module: `swreg_i2c_slave`

## Requirements
- R1: The 7-bit bus address is the parameter `ADDR_PREFIX` (5 bits, sent first) followed by `addr_sel[1]` and then `addr_sel[0]`. The 8th bit of the address byte is the direction bit (1 = read). On a match, the block pulls `sda_oe` high for the whole 9th clock.
- R2: On an address mismatch, the block never asserts `sda_oe`, ignores every later byte, and leaves the register unchanged until the next START.
- R3: In a write, data arrives MSB first. Register bit i drives `sw_en[i]`, and a 1 means the switch is on. Every data byte is acknowledged in its 9th clock.
- R4: Each byte of a multi-byte write takes effect on its own, without the master sending the address again.
- R5: In a read, the block sends the register MSB first by pulling low for 0 bits. A master ACK starts another byte of the same value. A master NACK makes the block release the line until the next START.
- R6: While `rst_n` is low (sampled on the clock), the register, `sw_en` and `sda_oe` are all cleared. They stay zero until a valid write completes.
- R7: A level on `scl_i` or `sda_i` that lasts fewer than `FILT_LEN` system clocks has no effect.
- R8: When a byte is applied, bits going from 1 to 0 clear first. Bits going from 0 to 1 set exactly `BBM_GAP` clocks later. No single clock both clears and sets bits, and `sw_en` is never set where the stored register is 0.
- R9: A START in the middle of a byte aborts the transfer and restarts address reception. The partial byte is never applied.
- R10: `sda_oe` is low in every bit the block does not own: idle, address bits, written data bits, and the master acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 2 | Address select pins; bit 1 is address bit 1 and bit 0 is address bit 0 |
| sda_oe | output | 1 | 1 = pull the data line low |
| sw_en | output | 8 | Switch enables; bit i drives switch i+1 |

## Verification
A bus edge reaches the protocol logic 2 + `FILT_LEN` clocks after it appears on a pin (6 clocks with the defaults). The acknowledge or read-bit drive follows one clock later, and a write strobe lands on `sw_en` after one more clock. With the defaults, bits that must open appear about 8 clocks after the 8th rising edge of `scl_i`, and bits that must close appear `BBM_GAP` (16) clocks after that.

The bench drives each bus phase for 64 clocks. It samples `sda_oe` 32 clocks into an SCL high phase, far past the 7-clock path. The break-before-make check samples 2 clocks after the last rising edge (old value still held), then 12 clocks after it (open bits only), then a full bus clock later (final value). A glitch lasts `FILT_LEN`-1 clocks, which is just one clock short of acceptance.

// File: rtl/swreg_pkg.sv
// Shared widths and the bus-state encoding for the switch-enable register.
package swreg_pkg;
    localparam int DATA_W = 8;              // control word width
    localparam int ADDR_W = 7;              // bus address width
    localparam int PIN_W  = 2;              // address bits taken from pins
    localparam int PRE_W  = ADDR_W - PIN_W; // fixed address prefix width

    typedef enum logic [2:0] {
        ST_IDLE,      // not addressed, waiting for START
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_ACK,  // address acknowledge slot
        ST_WDATA,     // shifting in a write byte
        ST_WACK,      // write-byte acknowledge slot
        ST_RDATA,     // driving a read byte
        ST_RACK       // master acknowledge slot after a read byte
    } bus_state_t;
endpackage

// File: rtl/swreg_deglitch.sv
// Two-flop synchronizer followed by a persistence filter. The output follows
// the synchronized input only after it has differed for FILT_LEN consecutive
// clocks. Assumes FILT_LEN >= 1. Latency is 2 + FILT_LEN clocks.
module swreg_deglitch #(
    parameter int   FILT_LEN  = 4,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    // Synchronize, then count cycles of disagreement before accepting a level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= {2{RESET_VAL}};
            dout <= RESET_VAL;
            cnt  <= '0;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                dout <= sync[1];
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // A new filtered level must match what the synchronizer presented.
    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(sync[1]) == dout)); // R7
endmodule

// File: rtl/swreg_bus_fsm.sv
// Bus target protocol engine. It works on filtered SCL/SDA, detects START and
// STOP, matches the address, acknowledges, and shifts write and read bytes.
// It raises wr_stb for one clock when a full write byte is in. Assumes clean
// (filtered) inputs and no clock stretching.
module swreg_bus_fsm
    import swreg_pkg::*;
#(
    parameter logic [PRE_W-1:0] ADDR_PREFIX = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam int CW = $clog2(DATA_W + 1);

    bus_state_t        state;
    logic              scl_q, sda_q;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] sh, tx, byte_in;
    logic              rw, ack_on;
    logic              start, stop, scl_rise, scl_fall;
    logic [ADDR_W-1:0] own_addr;

    // Edge and bus-condition decode from the previous filtered sample.
    always_comb begin
        start    = scl && scl_q && sda_q && !sda;
        stop     = scl && scl_q && !sda_q && sda;
        scl_rise = scl && !scl_q;
        scl_fall = !scl && scl_q;
        byte_in  = {sh[DATA_W-2:0], sda};
        own_addr = {ADDR_PREFIX, addr_pins};
    end

    // Protocol sequencing: address, acknowledge, write and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            ack_on  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            scl_q  <= scl;
            sda_q  <= sda;
            wr_stb <= 1'b0;
            if (start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop) begin
                state  <= ST_IDLE;
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (scl_rise) begin
                        sh <= byte_in;
                        if (cnt == CW'(DATA_W - 1)) begin
                            cnt <= '0;
                            if (byte_in[DATA_W-1:1] == own_addr) begin
                                rw    <= byte_in[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR_ACK, ST_WACK: if (scl_fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1;
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            cnt    <= '0;
                            if (state == ST_ADDR_ACK && rw) begin
                                state  <= ST_RDATA;
                                tx     <= rd_data;
                                sda_oe <= !rd_data[DATA_W-1];
                            end else begin
                                state  <= ST_WDATA;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: if (scl_rise) begin
                        sh <= byte_in;
                        if (cnt == CW'(DATA_W - 1)) begin
                            cnt     <= '0;
                            wr_stb  <= 1'b1;
                            wr_data <= byte_in;
                            state   <= ST_WACK;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == CW'(DATA_W)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx     <= {tx[DATA_W-2:0], 1'b0};
                                sda_oe <= !tx[DATA_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (sda) state <= ST_IDLE;
                            else     ack_on <= 1'b1;
                        end else if (scl_fall && ack_on) begin
                            ack_on <= 1'b0;
                            cnt    <= '0;
                            tx     <= rd_data;
                            sda_oe <= !rd_data[DATA_W-1];
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR || state == ST_WDATA) |-> !sda_oe); // R10
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_ADDR && !sda_oe && !wr_stb)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4
endmodule

// File: rtl/swreg_bbm.sv
// Holds the control word and sequences the switch enables break-before-make.
// Bits that turn off are cleared in the cycle after a write. Bits that turn on
// follow BBM_GAP clocks later. A new write during the gap restarts it.
// Assumes BBM_GAP >= 1.
module swreg_bbm
    import swreg_pkg::*;
#(
    parameter int BBM_GAP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word_q,
    output logic [DATA_W-1:0] sw_en
);
    localparam int GW = $clog2(BBM_GAP + 1);

    logic          pending;
    logic [GW-1:0] gap_cnt;

    // Store the word, open switches at once, close new ones after the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            sw_en   <= '0;
            pending <= 1'b0;
            gap_cnt <= '0;
        end else if (wr_stb) begin
            word_q  <= wr_data;
            sw_en   <= sw_en & wr_data;
            pending <= |(wr_data & ~sw_en);
            gap_cnt <= '0;
        end else if (pending) begin
            if (gap_cnt == GW'(BBM_GAP - 1)) begin
                sw_en   <= word_q;
                pending <= 1'b0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    AST_NO_MAKE_WITH_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sw_en & $past(sw_en)) != '0) |-> ((sw_en & ~$past(sw_en)) == '0)); // R8
    AST_EN_WITHIN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en & ~word_q) == '0); // R8
endmodule

// File: rtl/swreg_i2c_slave.sv
// Top level: filters both bus lines, runs the protocol engine and drives the
// switch enables through the break-before-make sequencer. The data line is
// open-drain: sda_oe = 1 pulls it low.
module swreg_i2c_slave
    import swreg_pkg::*;
#(
    parameter logic [PRE_W-1:0] ADDR_PREFIX = 5'b10011,
    parameter int               FILT_LEN    = 4,
    parameter int               BBM_GAP     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  addr_sel,
    output logic              sda_oe,
    output logic [DATA_W-1:0] sw_en
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, flt;
    logic              wr_stb;
    logic [DATA_W-1:0] wr_data, word_q;

    assign raw = {sda_i, scl_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_filt
        swreg_deglitch #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .dout (flt[i])
        );
    end

    swreg_bus_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (flt[0]),
        .sda      (flt[1]),
        .addr_pins(addr_sel),
        .rd_data  (word_q),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    swreg_bbm #(.BBM_GAP(BBM_GAP)) u_bbm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wr_data(wr_data),
        .word_q (word_q),
        .sw_en  (sw_en)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (sw_en == '0 && !sda_oe)); // R6
endmodule

// File: tb/sim_swreg_i2c_slave.sv
module sim_swreg_i2c_slave;
    localparam logic [4:0] PRE = 5'b10011;
    localparam int Q    = 64;   // clocks per SCL phase
    localparam int FILT = 4;
    localparam int GAP  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_m = 1'b1;
    logic [1:0] pins = 2'b00;
    logic       sda_oe;
    logic [7:0] sw_en;
    wire        sda_bus = sda_m & ~sda_oe;

    int runs = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    swreg_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .addr_sel(pins), .sda_oe(sda_oe), .sw_en(sw_en)
    );

    // {pins, data}
    localparam logic [9:0] VEC [6] = '{
        {2'b00, 8'hA5}, {2'b01, 8'h00}, {2'b10, 8'hFF},
        {2'b11, 8'h5A}, {2'b00, 8'h81}, {2'b10, 8'h3C}
    };

    task automatic q(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_c();
        sda_m = 1'b1; q(Q/2); scl = 1'b1; q(Q); sda_m = 1'b0; q(Q); scl = 1'b0; q(Q/2);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; q(Q/2); scl = 1'b1; q(Q); sda_m = 1'b1; q(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; q(Q/2); scl = 1'b1; q(Q); scl = 1'b0; q(Q/2);
    endtask

    task automatic get_ack(output logic ack);
        sda_m = 1'b1; q(Q/2); scl = 1'b1; q(Q/2); ack = sda_oe; q(Q/2); scl = 1'b0; q(Q/2);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_ack(ack);
    endtask

    task automatic read_byte(output logic [7:0] d, input logic m_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; q(Q/2); scl = 1'b1; q(Q/2); d[i] = sda_bus; q(Q/2); scl = 1'b0; q(Q/2);
        end
        sda_m = !m_ack; q(Q/2); scl = 1'b1; q(Q); scl = 1'b0; q(Q/2);
    endtask

    task automatic write_word(input logic [7:0] d);
        logic a;
        start_c();
        write_byte({PRE, pins, 1'b0}, a); chk("R1 address ack", {7'd0, a}, 8'd1);
        write_byte(d, a);                  chk("R3 data ack", {7'd0, a}, 8'd1);
        stop_c();
        q(2 * Q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] r;
        q(5);
        chk("R6 reset sw_en", sw_en, 8'h00);
        chk("R6 reset sda_oe", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        q(20);

        // Table walk: write each word, read it back with NACK.
        for (int k = 0; k < 6; k++) begin
            pins = VEC[k][9:8];
            write_word(VEC[k][7:0]);
            chk("R3 switch pattern", sw_en, VEC[k][7:0]);
            start_c();
            write_byte({PRE, pins, 1'b1}, a); chk("R1 read address ack", {7'd0, a}, 8'd1);
            read_byte(r, 1'b0);                chk("R5 read value", r, VEC[k][7:0]);
            chk("R5 released after NACK", {7'd0, sda_oe}, 8'd0);
            stop_c();
            chk("R10 idle released", {7'd0, sda_oe}, 8'd0);
        end

        // R2: wrong pin bits, no ack, data ignored.
        pins = 2'b01;
        write_word(8'h0F);
        start_c();
        write_byte({PRE, 2'b10, 1'b0}, a); chk("R2 mismatch no ack", {7'd0, a}, 8'd0);
        write_byte(8'hF0, a);              chk("R2 data no ack", {7'd0, a}, 8'd0);
        stop_c(); q(2 * Q);
        chk("R2 register unchanged", sw_en, 8'h0F);

        // R4: repeated write, each byte applied on its own.
        start_c();
        write_byte({PRE, pins, 1'b0}, a);
        write_byte(8'h11, a); q(Q); chk("R4 first byte", sw_en, 8'h11);
        write_byte(8'h22, a); q(Q); chk("R4 second byte", sw_en, 8'h22);
        write_byte(8'hC3, a); q(Q); chk("R4 third byte", sw_en, 8'hC3);
        chk("R3 repeat byte ack", {7'd0, a}, 8'd1);
        stop_c(); q(Q);

        // R8: break-before-make timing, 0x3C -> 0x0F.
        write_word(8'h3C);
        start_c();
        write_byte({PRE, pins, 1'b0}, a);
        for (int i = 7; i >= 1; i--) put_bit(8'h0F >> i);
        sda_m = 1'b1; q(Q/2); scl = 1'b1;
        q(2);  chk("R8 old value held", sw_en, 8'h3C);
        q(10); chk("R8 opens first", sw_en, 8'h0C);
        q(Q - 12); scl = 1'b0; q(Q/2);
        get_ack(a); chk("R8 final value", sw_en, 8'h0F);
        stop_c();

        // R5: master ACK then a second byte.
        start_c();
        write_byte({PRE, pins, 1'b1}, a);
        read_byte(r, 1'b1); chk("R5 first read", r, 8'h0F);
        read_byte(r, 1'b0); chk("R5 repeat read", r, 8'h0F);
        stop_c();

        // R9: START mid-byte aborts; partial byte dropped.
        start_c();
        write_byte({PRE, pins, 1'b0}, a);
        for (int i = 7; i >= 4; i--) put_bit(8'hAA >> i);
        start_c();
        chk("R9 partial byte not applied", sw_en, 8'h0F);
        write_byte({PRE, pins, 1'b0}, a); chk("R9 readdress ack", {7'd0, a}, 8'd1);
        write_byte(8'h81, a);
        stop_c(); q(2 * Q);
        chk("R9 new transfer applied", sw_en, 8'h81);

        // R7: short SCL and SDA pulses ignored during a write byte.
        start_c();
        write_byte({PRE, pins, 1'b0}, a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 8'h6C >> i; q(Q/4);
            if (i == 3) begin scl = 1'b1; q(FILT - 1); scl = 1'b0; end
            q(Q/4); scl = 1'b1; q(Q/2);
            if (i == 5) begin sda_m = !sda_m; q(FILT - 1); sda_m = !sda_m; end
            q(Q/2); scl = 1'b0; q(Q/2);
        end
        get_ack(a);
        stop_c(); q(2 * Q);
        chk("R7 glitches ignored", sw_en, 8'h6C);

        // R6: reset mid-use clears everything.
        rst_n = 1'b0; q(3);
        chk("R6 reset clears sw_en", sw_en, 8'h00);
        rst_n = 1'b1; q(10);
        start_c();
        write_byte({PRE, pins, 1'b1}, a);
        read_byte(r, 1'b0); chk("R6 register cleared", r, 8'h00);
        stop_c();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule